// File: doc/BRIEF.md
# DMA Handshake Pause Controller

This block is the control logic for one DMA channel that an external master steers through a request, acknowledge and done handshake. The master starts a transfer with a rising edge on the request input. The channel then raises acknowledge and moves data. The movement is abstracted as a beat interface: a valid pulse, a byte count and a flag that marks descriptor-fetch traffic. When the programmed total byte count runs out, the channel issues a one-cycle done pulse and is ready for a new command.

When pausing is armed, the channel stops by itself after a programmable quantum of data bytes has moved. It then waits for another request edge before it resumes. A 4-bit bandwidth field selects a quantum of 2^(field+6) bytes. Descriptor-fetch beats in the chaining modes never count toward either the quantum or the total. A separate enable gates the whole handshake.

Top module: `dma_xfer_gate`

## Requirements
- R1: After reset, acknowledge, done, the started status, the busy status and the configuration-error flag are all low.
- R2: With the handshake enabled, a rising edge of the request input in the idle state raises acknowledge, started and busy on the next cycle. A request held high never starts a second transfer.
- R3: Each counted data beat lowers the remaining byte count by its byte value, saturating at zero. The beat that brings the count to zero produces a one-cycle done pulse. In that same cycle acknowledge, started and busy go low.
- R4: With pausing armed, once the data bytes moved since the last start or resume reach 2^(bwSel+6), the channel pauses. In the paused state acknowledge is low, started is low, busy stays high and no done pulse appears. The beat that finishes the transfer completes it rather than pausing.
- R5: In the paused state, a rising request edge resumes the channel on the next cycle with acknowledge and started high. The quantum count restarts from zero.
- R6: With pausing disarmed, the channel runs from the first request edge to completion without pausing.
- R7: xferMode encodes 0 basic direct, 1 basic chaining, 2 extended direct, 3 extended chaining. In chaining modes (1, 3), beats with beatDesc high change neither the remaining count nor the quantum. In direct modes (0, 2), beatDesc is ignored and every beat counts as data.
- R8: A pause-arm write (pauseWr with pauseWrVal high) in a chaining mode while the remaining count is nonzero sets cfgErr and leaves pausing disarmed. Any accepted pause write clears cfgErr. Direct modes accept arming at any count.
- R9: While extCtlEn is low, request edges are ignored and dmaAck and dmaDone stay low.
- R10: Beats presented while the channel is idle or paused are ignored. The remaining byte count changes only through cmdLoad or a counted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extCtlEn | input | 1 | Enables the external handshake |
| xferMode | input | 2 | Transfer mode (see R7) |
| bwSel | input | 4 | Bandwidth field, quantum 2^(bwSel+6) bytes |
| pauseWr | input | 1 | Write strobe for the pause-arm bit |
| pauseWrVal | input | 1 | Value written to the pause-arm bit |
| cmdLoad | input | 1 | Loads the total byte count |
| cmdBytes | input | 16 | Total byte count to load |
| beatValid | input | 1 | A beat moved this cycle |
| beatBytes | input | 8 | Bytes in the beat |
| beatDesc | input | 1 | Beat is a descriptor fetch |
| dmaReq | input | 1 | External request, rising edge starts or resumes |
| dmaAck | output | 1 | Transfer in progress |
| dmaDone | output | 1 | One-cycle completion pulse |
| chanStarted | output | 1 | Channel-started status |
| chanBusy | output | 1 | Channel-busy status |
| cfgErr | output | 1 | Rejected pause-arm write |

## Verification
A wrong byte or quantum count inside the block shows up at the ports as a done pulse or a pause on the wrong beat. That error is visible one cycle after the offending beat. A state register stuck in the run or pause state shows as acknowledge and busy disagreeing with the expected pause or completion in that same cycle. The sweeps therefore compare, for every mode, bandwidth setting, beat size and total, the exact number of beats to completion and the number of pauses against closed-form ceiling arithmetic. They also check the status outputs at every pause and completion.

// File: rtl/xfer_gate_pkg.sv
package xfer_gate_pkg;

  typedef enum logic [1:0] {
    M_BDIRECT = 2'd0,
    M_BCHAIN  = 2'd1,
    M_XDIRECT = 2'd2,
    M_XCHAIN  = 2'd3
  } xferMode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } chState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic qClr;     // restart the quantum count
    logic consume;  // count the current beat
  } dpStrobe_t;

endpackage

// File: rtl/xfer_gate_dp.sv
module xfer_gate_dp
  import xfer_gate_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 8,
  parameter int BW_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              cmdLoad,
  input  logic [CNT_W-1:0]  cmdBytes,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic [BW_W-1:0]   bwSel,
  output logic              cntZero,
  output logic              lastBeat,
  output logic              quantumHit
);

  localparam int QCNT_W = (1 << BW_W) + 6;
  localparam int QLIM_W = QCNT_W + 1;

  logic [CNT_W-1:0]  remCnt;
  logic [QCNT_W-1:0] qCnt;
  logic [CNT_W-1:0]  beatRem;
  logic [QLIM_W-1:0] qSum;
  logic [QLIM_W-1:0] qLimit;

  assign beatRem    = CNT_W'(beatBytes);
  assign cntZero    = (remCnt == '0);
  assign lastBeat   = (remCnt <= beatRem);
  assign qSum       = QLIM_W'(qCnt) + QLIM_W'(beatBytes);
  assign qLimit     = QLIM_W'(1) << (int'(bwSel) + 6);
  assign quantumHit = (qSum >= qLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt <= '0;
    end else if (cmdLoad) begin
      remCnt <= cmdBytes;
    end else if (strb.consume) begin
      remCnt <= lastBeat ? '0 : remCnt - beatRem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt <= '0;
    end else if (strb.qClr) begin
      qCnt <= '0;
    end else if (strb.consume) begin
      qCnt <= qSum[QCNT_W-1:0];
    end
  end

  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.consume && !cmdLoad) |=> $stable(remCnt)); // R10

  AST_REM_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && !cmdLoad) |=> (remCnt <= $past(remCnt))); // R3

endmodule

// File: rtl/xfer_gate_ctrl.sv
module xfer_gate_ctrl
  import xfer_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      extCtlEn,
  input  logic      dmaReq,
  input  logic      pauseWr,
  input  logic      pauseWrVal,
  input  logic [1:0] xferMode,
  input  logic      beatValid,
  input  logic      beatDesc,
  input  logic      cntZero,
  input  logic      lastBeat,
  input  logic      quantumHit,
  output dpStrobe_t strb,
  output logic      runAck,
  output logic      doneP,
  output logic      started,
  output logic      busy,
  output logic      cfgErr
);

  chState_t state, stateNext;
  logic reqPrev;
  logic reqEdge;
  logic chainMode;
  logic dataBeat;
  logic finishNow;
  logic pauseNow;
  logic resumeNow;
  logic pauseOn;
  logic armReject;

  assign chainMode = (xferMode == M_BCHAIN) || (xferMode == M_XCHAIN);
  assign reqEdge   = extCtlEn && dmaReq && !reqPrev;
  assign dataBeat  = beatValid && !(chainMode && beatDesc);

  assign strb.consume = (state == ST_RUN) && dataBeat;
  assign finishNow    = strb.consume && lastBeat;
  assign pauseNow     = strb.consume && !lastBeat && pauseOn && quantumHit;
  assign resumeNow    = (state != ST_RUN) && reqEdge;
  assign strb.qClr    = pauseNow || resumeNow;
  assign armReject    = pauseWr && pauseWrVal && chainMode && !cntZero;
  assign runAck       = (state == ST_RUN);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqEdge) stateNext = ST_RUN;
      ST_RUN: begin
        if (finishNow)     stateNext = ST_IDLE;
        else if (pauseNow) stateNext = ST_PAUSE;
      end
      ST_PAUSE: if (reqEdge) stateNext = ST_RUN;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqPrev <= 1'b0;
      doneP   <= 1'b0;
      started <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state   <= stateNext;
      reqPrev <= dmaReq;
      doneP   <= finishNow;
      if (resumeNow)                  started <= 1'b1;
      else if (pauseNow || finishNow) started <= 1'b0;
      if (resumeNow)      busy <= 1'b1;
      else if (finishNow) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseOn <= 1'b0;
      cfgErr  <= 1'b0;
    end else if (pauseWr) begin
      if (armReject) begin
        cfgErr <= 1'b1;
      end else begin
        pauseOn <= pauseWrVal;
        cfgErr  <= 1'b0;
      end
    end
  end

  AST_START_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (reqEdge && state == ST_IDLE) |=> (runAck && started && busy)); // R2

  AST_STARTED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    started |-> busy); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (!busy && !started && !runAck)); // R3

  AST_PAUSE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE) |-> (busy && !started && !doneP)); // R4

  AST_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE && reqEdge) |=> (runAck && started)); // R5

  AST_NO_PAUSE_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseOn && state == ST_RUN) |=> (state != ST_PAUSE)); // R6

  AST_DESC_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatDesc && chainMode) |-> !strb.consume); // R7

  AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    armReject |=> (cfgErr && pauseOn == $past(pauseOn))); // R8

  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!extCtlEn && state == ST_IDLE) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/dma_xfer_gate.sv
module dma_xfer_gate
  import xfer_gate_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 8,
  parameter int BW_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extCtlEn,
  input  logic [1:0]        xferMode,
  input  logic [BW_W-1:0]   bwSel,
  input  logic              pauseWr,
  input  logic              pauseWrVal,
  input  logic              cmdLoad,
  input  logic [CNT_W-1:0]  cmdBytes,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic              beatDesc,
  input  logic              dmaReq,
  output logic              dmaAck,
  output logic              dmaDone,
  output logic              chanStarted,
  output logic              chanBusy,
  output logic              cfgErr
);

  dpStrobe_t strb;
  logic cntZero, lastBeat, quantumHit;
  logic runAck, doneP;

  xfer_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extCtlEn   (extCtlEn),
    .dmaReq     (dmaReq),
    .pauseWr    (pauseWr),
    .pauseWrVal (pauseWrVal),
    .xferMode   (xferMode),
    .beatValid  (beatValid),
    .beatDesc   (beatDesc),
    .cntZero    (cntZero),
    .lastBeat   (lastBeat),
    .quantumHit (quantumHit),
    .strb       (strb),
    .runAck     (runAck),
    .doneP      (doneP),
    .started    (chanStarted),
    .busy       (chanBusy),
    .cfgErr     (cfgErr)
  );

  xfer_gate_dp #(
    .CNT_W  (CNT_W),
    .BEAT_W (BEAT_W),
    .BW_W   (BW_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdLoad    (cmdLoad),
    .cmdBytes   (cmdBytes),
    .beatBytes  (beatBytes),
    .bwSel      (bwSel),
    .cntZero    (cntZero),
    .lastBeat   (lastBeat),
    .quantumHit (quantumHit)
  );

  assign dmaAck  = runAck && extCtlEn;
  assign dmaDone = doneP && extCtlEn;

  AST_ACK_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaAck && dmaDone)); // R3

endmodule

// File: tb/dma_xfer_gate_bench.sv
module dma_xfer_gate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extCtlEn = 1'b0;
  logic [1:0]  xferMode = 2'd0;
  logic [3:0]  bwSel = 4'd0;
  logic        pauseWr = 1'b0;
  logic        pauseWrVal = 1'b0;
  logic        cmdLoad = 1'b0;
  logic [15:0] cmdBytes = 16'd0;
  logic        beatValid = 1'b0;
  logic [7:0]  beatBytes = 8'd0;
  logic        beatDesc = 1'b0;
  logic        dmaReq = 1'b0;
  logic        dmaAck, dmaDone, chanStarted, chanBusy, cfgErr;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_xfer_gate u_dma_xfer_gate (
    .clk(clk), .rstN(rstN), .extCtlEn(extCtlEn), .xferMode(xferMode),
    .bwSel(bwSel), .pauseWr(pauseWr), .pauseWrVal(pauseWrVal),
    .cmdLoad(cmdLoad), .cmdBytes(cmdBytes), .beatValid(beatValid),
    .beatBytes(beatBytes), .beatDesc(beatDesc), .dmaReq(dmaReq),
    .dmaAck(dmaAck), .dmaDone(dmaDone), .chanStarted(chanStarted),
    .chanBusy(chanBusy), .cfgErr(cfgErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nChk = nChk + 1;
      nFail = nFail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk = nChk + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseReq();
    dmaReq = 1'b1;
    tick();
    dmaReq = 1'b0;
  endtask

  task automatic writePause(input bit v);
    pauseWr = 1'b1;
    pauseWrVal = v;
    tick();
    pauseWr = 1'b0;
  endtask

  task automatic loadCount(input int total);
    cmdLoad = 1'b1;
    cmdBytes = 16'(total);
    tick();
    cmdLoad = 1'b0;
  endtask

  // feed beats while running, resume on pauses, stop at done
  task automatic pump(input int bsz, input bit useDesc, input string ptag,
                      output int beats, output int pauses, output int dones);
    beats = 0; pauses = 0; dones = 0;
    for (int it = 0; it < 4000 && dones == 0; it++) begin
      if (useDesc) begin
        beatValid = 1'b1; beatDesc = 1'b1; beatBytes = 8'd200;
        tick();
        chk(dmaAck == 1'b1 && dmaDone == 1'b0, "R7 desc beat not counted", int'(dmaAck), 1);
      end
      beatValid = 1'b1; beatDesc = 1'b0; beatBytes = 8'(bsz);
      tick();
      beatValid = 1'b0;
      beats++;
      if (dmaDone) begin
        dones++;
        chk(!dmaAck && !chanBusy && !chanStarted, "R3 status at done",
            int'({dmaAck, chanBusy, chanStarted}), 0);
        tick();
        chk(dmaDone == 1'b0, "R3 done single cycle", int'(dmaDone), 0);
      end else if (!dmaAck) begin
        pauses++;
        chk(chanBusy && !chanStarted, {ptag, " paused status"},
            int'({chanBusy, chanStarted}), 2);
        tick();
        chk(!dmaAck && !dmaDone && chanBusy, {ptag, " pause holds"},
            int'({dmaAck, dmaDone, chanBusy}), 1);
        pulseReq();
        chk(dmaAck && chanStarted, "R5 resume", int'({dmaAck, chanStarted}), 3);
      end
    end
  endtask

  initial begin
    int beats, pauses, dones;
    extCtlEn = 1'b1;
    repeat (3) tick();
    chk(!dmaAck && !dmaDone && !chanStarted && !chanBusy && !cfgErr, "R1 reset state",
        int'({dmaAck, dmaDone, chanStarted, chanBusy, cfgErr}), 0);
    rstN = 1'b1;
    tick();
    chk(!dmaAck && !chanBusy, "R1 after release", int'({dmaAck, chanBusy}), 0);

    // R9: disabled handshake ignores request
    extCtlEn = 1'b0; xferMode = 2'd0;
    loadCount(64);
    dmaReq = 1'b1;
    tick();
    chk(!dmaAck && !chanBusy && !dmaDone, "R9 gated request", int'({dmaAck, chanBusy}), 0);
    extCtlEn = 1'b1;
    tick(); tick();
    chk(!chanBusy, "R2 held level no start", int'(chanBusy), 0);
    dmaReq = 1'b0;
    tick();
    dmaReq = 1'b1;
    tick();
    chk(dmaAck && chanStarted && chanBusy, "R2 edge starts",
        int'({dmaAck, chanStarted, chanBusy}), 7);
    beatValid = 1'b1; beatBytes = 8'd64; beatDesc = 1'b0;
    tick();
    beatValid = 1'b0;
    chk(dmaDone == 1'b1, "R3 done on last beat", int'(dmaDone), 1);
    repeat (4) tick();
    chk(!chanBusy && !dmaAck, "R2 held level no retrigger", int'(chanBusy), 0);
    dmaReq = 1'b0;
    tick();

    // R10: beats while idle are ignored
    writePause(1'b0);
    loadCount(64);
    beatValid = 1'b1; beatBytes = 8'd64;
    tick();
    beatValid = 1'b0;
    chk(!chanBusy && !dmaDone, "R10 idle beat ignored", int'(dmaDone), 0);
    pulseReq();
    beatValid = 1'b1; beatBytes = 8'd32;
    tick();
    beatValid = 1'b0;
    chk(dmaAck && !dmaDone, "R10 count intact", int'(dmaDone), 0);
    beatValid = 1'b1;
    tick();
    beatValid = 1'b0;
    chk(dmaDone == 1'b1, "R10 completes at 64", int'(dmaDone), 1);
    tick();

    // R7: direct mode ignores the descriptor flag
    xferMode = 2'd2;
    loadCount(64);
    pulseReq();
    beatValid = 1'b1; beatDesc = 1'b1; beatBytes = 8'd64;
    tick();
    beatValid = 1'b0; beatDesc = 1'b0;
    chk(dmaDone == 1'b1, "R7 direct flagged beat counts", int'(dmaDone), 1);
    tick();

    // R8: arming with nonzero count in chaining mode is rejected
    xferMode = 2'd1; bwSel = 4'd0;
    loadCount(100);
    writePause(1'b1);
    chk(cfgErr == 1'b1, "R8 reject sets error", int'(cfgErr), 1);
    pulseReq();
    pump(16, 1'b0, "R8", beats, pauses, dones);
    chk(beats == 7 && pauses == 0, "R8 stays disarmed", pauses, 0);
    writePause(1'b0);
    chk(cfgErr == 1'b0, "R8 accepted write clears error", int'(cfgErr), 0);
    // direct mode accepts arming with a nonzero count
    xferMode = 2'd0;
    loadCount(128);
    writePause(1'b1);
    chk(cfgErr == 1'b0, "R8 direct accepts arm", int'(cfgErr), 0);
    pulseReq();
    pump(16, 1'b0, "R4", beats, pauses, dones);
    chk(pauses == 1 && beats == 8, "R8 direct armed pauses", pauses, 1);

    // sweep: mode x bandwidth x arm x beat size x total
    for (int m = 0; m < 4; m++) begin
      for (int bw = 0; bw < 2; bw++) begin
        for (int pe = 0; pe < 2; pe++) begin
          for (int bi = 0; bi < 4; bi++) begin
            for (int ti = 0; ti < 3; ti++) begin
              int bsz, total, q, nb, k, expP;
              string ptag;
              bsz   = (bi == 0) ? 16 : (bi == 1) ? 24 : (bi == 2) ? 64 : 100;
              total = (ti == 0) ? 64 : (ti == 1) ? 200 : 1000;
              q     = 1 << (bw + 6);
              nb    = (total + bsz - 1) / bsz;
              k     = (q + bsz - 1) / bsz;
              expP  = (pe != 0) ? (nb - 1) / k : 0;
              ptag  = (pe != 0) ? "R4" : "R6";
              xferMode = 2'(m); bwSel = 4'(bw);
              writePause(pe[0]);
              chk(cfgErr == 1'b0, "R8 arm at zero count", int'(cfgErr), 0);
              loadCount(total);
              pulseReq();
              chk(dmaAck && chanStarted && chanBusy, "R2 start in sweep",
                  int'({dmaAck, chanStarted, chanBusy}), 7);
              pump(bsz, m[0], ptag, beats, pauses, dones);
              chk(beats == nb, "R3 beats to completion", beats, nb);
              chk(pauses == expP, {ptag, " pause count"}, pauses, expP);
              chk(dones == 1, "R3 one done", dones, 1);
            end
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule